// File: doc/BRIEF.md
# Frame-Synchronous Payload Scrambler

This block whitens a byte stream carried in SONET/SDH-style frames, so that a long run of identical line bits is unlikely. It keeps track of where each byte sits in the frame. A frame is 9 rows deep, and each row holds 3*N overhead columns followed by 87*N payload columns. A start-of-frame strobe marks the first overhead byte of the top row. Every byte is XORed with the output of a 7-bit pseudo-random generator, except the overhead bytes of the top row. Those overhead bytes must stay readable so that the far end can find the frame.

The generator is restarted from a fixed seed at each frame start. This makes the operation its own inverse: the receiver uses an identical instance to undo it. The generator steps only on bytes that it actually scrambles. Cycles with the valid signal low, and top-row overhead bytes, leave its state untouched. Once the first strobe has been seen, the position counters run on by themselves. If a frame length of bytes goes by with no new strobe, the block treats the next byte as a frame start.

Top module: `sonet_frame_scrambler`

## Requirements
- R1: While reset is asserted, out_valid, out_sof and out_data are all zero.
- R2: Until the first byte with in_sof high has been accepted, every valid byte passes through unchanged.
- R3: The first 3*N valid bytes of each frame, counted from the strobe byte itself, pass through unchanged.
- R4: The first payload byte of a frame (valid byte number 3*N after the strobe) is XORed with 8'hFE. The key comes from the generator x^7+x^6+1, seeded with all ones, with the first generated bit placed in the most significant bit. Each following scrambled byte takes the next 8 generator bits.
- R5: The generator advances only on valid bytes that are scrambled. Idle cycles anywhere in the stream do not alter the key sequence seen by later bytes.
- R6: Overhead columns of rows 2 to 9 are scrambled, continuing the same key sequence.
- R7: A strobe that arrives before the current frame has ended restarts both the position and the key sequence at once.
- R8: With PIPE=1, out_valid and out_sof equal in_valid and in_sof of the previous cycle, and out_data carries the result for that byte.
- R9: Two instances in series return the original byte stream, sideband signals included.
- R10: After 810*N valid bytes with no new strobe, the next byte is treated as the start of a frame: its row-1 overhead passes unchanged and the key restarts at 8'hFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | Marks the first top-row overhead byte of a frame; meaningful only with in_valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte qualifier |
| out_sof | output | 1 | Frame-start marker aligned with out_data |
| out_data | output | 8 | Scrambled (or descrambled) byte |

## Verification
The hardest case to reach from the ports is the frame wrap with no strobe. The position counters must run a full 810*N valid bytes past a strobe, while idle cycles are scattered through the stream, before the implicit restart can be seen. The bench builds with N=1 and streams more than two full frames after a single strobe, with random gaps, so that both the wrap and the rows-2-to-9 overhead are covered. A later strobe cuts a frame short part-way through. A second instance in series checks that the stream comes back unchanged over all of these cases.

// File: rtl/fss_pkg.sv
package fss_pkg;
   localparam int LFSR_W      = 7;
   localparam int BYTE_W      = 8;
   localparam int FRAME_ROWS  = 9;
   localparam int OH_PER_STS  = 3;
   localparam int PL_PER_STS  = 87;

   typedef logic [LFSR_W-1:0] lfsr_t;
   typedef logic [BYTE_W-1:0] byte_t;

   localparam lfsr_t LFSR_SEED = '1;

   // one bit step of x^7 + x^6 + 1; the bit emitted is the MSB before the step
   function automatic lfsr_t lfsr_step(input lfsr_t s);
      return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
   endfunction
endpackage

// File: rtl/fss_frame_pos.sv
module fss_frame_pos
   import fss_pkg::*;
#(
   parameter int N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_sof,
   output logic cur_scramble,
   output logic cur_frame_start
);
   localparam int ROW_COLS = (OH_PER_STS + PL_PER_STS) * N;
   localparam int OH_COLS  = OH_PER_STS * N;
   localparam int COL_W    = $clog2(ROW_COLS);
   localparam int ROW_W    = $clog2(FRAME_ROWS);

   logic             locked_q;
   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;

   logic             cur_locked;
   logic [COL_W-1:0] cur_col;
   logic [ROW_W-1:0] cur_row;
   logic             cur_top_oh;

   always_comb begin
      cur_locked = in_sof | locked_q;
      cur_col    = in_sof ? '0 : col_q;
      cur_row    = in_sof ? '0 : row_q;
      cur_top_oh = (cur_row == '0) && (cur_col < COL_W'(OH_COLS));
      cur_frame_start = cur_locked && (cur_row == '0) && (cur_col == '0);
      cur_scramble    = cur_locked && !cur_top_oh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         col_q    <= '0;
         row_q    <= '0;
      end else if (in_valid) begin
         locked_q <= cur_locked;
         if (cur_col == COL_W'(ROW_COLS - 1)) begin
            col_q <= '0;
            row_q <= (cur_row == ROW_W'(FRAME_ROWS - 1)) ? '0 : cur_row + 1'b1;
         end else begin
            col_q <= cur_col + 1'b1;
            row_q <= cur_row;
         end
      end
   end
endmodule

// File: rtl/fss_keygen.sv
module fss_keygen
   import fss_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  in_valid,
   input  logic  reload,
   input  logic  advance,
   output byte_t keystream
);
   lfsr_t state_q;
   lfsr_t chain [0:BYTE_W];

   assign chain[0] = reload ? LFSR_SEED : state_q;

   for (genvar k = 0; k < BYTE_W; k++) begin : g_unroll
      assign keystream[BYTE_W-1-k] = chain[k][LFSR_W-1];
      assign chain[k+1]            = lfsr_step(chain[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= LFSR_SEED;
      else if (in_valid)
         state_q <= advance ? chain[BYTE_W] : chain[0];
   end
endmodule

// File: rtl/fss_out_stage.sv
module fss_out_stage
   import fss_pkg::*;
#(
   parameter bit PIPE = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  in_valid,
   input  logic  in_sof,
   input  byte_t in_data,
   input  byte_t key,
   input  logic  apply,
   output logic  out_valid,
   output logic  out_sof,
   output byte_t out_data
);
   byte_t mixed;
   assign mixed = in_data ^ (apply ? key : '0);

   if (PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
         end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid & in_sof;
            if (in_valid) out_data <= mixed;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_sof   = in_valid & in_sof;
      assign out_data  = mixed;
   end
endmodule

// File: rtl/sonet_frame_scrambler.sv
module sonet_frame_scrambler
   import fss_pkg::*;
#(
   parameter int N    = 3,
   parameter bit PIPE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_sof,
   input  logic [7:0] in_data,
   output logic       out_valid,
   output logic       out_sof,
   output logic [7:0] out_data
);
   if (N < 1 || N > 256) begin : g_bad_n
      $error("sonet_frame_scrambler: N must lie in 1..256");
   end

   logic  pos_scramble;
   logic  pos_frame_start;
   byte_t key;

   fss_frame_pos #(.N(N)) u_pos (
      .clk             (clk),
      .rst_n           (rst_n),
      .in_valid        (in_valid),
      .in_sof          (in_sof),
      .cur_scramble    (pos_scramble),
      .cur_frame_start (pos_frame_start)
   );

   fss_keygen u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .reload    (pos_frame_start),
      .advance   (pos_scramble),
      .keystream (key)
   );

   fss_out_stage #(.PIPE(PIPE)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_data   (in_data),
      .key       (key),
      .apply     (pos_scramble),
      .out_valid (out_valid),
      .out_sof   (out_sof),
      .out_data  (out_data)
   );
endmodule

// File: rtl/sonet_frame_scrambler_chk.sv
module sonet_frame_scrambler_chk #(
   parameter int N    = 3,
   parameter bit PIPE = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_sof,
   input logic [7:0] in_data,
   input logic       out_valid,
   input logic       out_sof,
   input logic [7:0] out_data
);
   localparam int OH  = 3 * N;
   localparam int CW  = $clog2(OH + 2) + 1;

   logic          seen_q;
   logic [CW-1:0] cnt_q;
   logic          cur_seen;
   logic [CW-1:0] cur_cnt;

   assign cur_seen = seen_q | in_sof;
   assign cur_cnt  = in_sof ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         cnt_q  <= '0;
      end else if (in_valid) begin
         seen_q <= cur_seen;
         cnt_q  <= (cur_cnt > CW'(OH)) ? cur_cnt : cur_cnt + 1'b1;
      end
   end

   if (PIPE) begin : g_seq
      p_reset_quiet_r1: assert property (@(posedge clk)
         !rst_n |=> (!out_valid && !out_sof && out_data == 8'h00));
      p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_idle_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      p_sof_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_sof) |=> out_sof);
      p_unlocked_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !cur_seen) |=> out_data == $past(in_data));
      p_top_oh_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cur_seen && cur_cnt < CW'(OH)) |=> out_data == $past(in_data));
      p_first_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cur_seen && cur_cnt == CW'(OH)) |=> out_data == ($past(in_data) ^ 8'hFE));
   end else begin : g_comb
      p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      p_unlocked_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !cur_seen) |-> out_data == in_data);
      p_top_oh_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cur_seen && cur_cnt < CW'(OH)) |-> out_data == in_data);
      p_first_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cur_seen && cur_cnt == CW'(OH)) |-> out_data == (in_data ^ 8'hFE));
   end
endmodule

bind sonet_frame_scrambler sonet_frame_scrambler_chk #(.N(N), .PIPE(PIPE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_sof   (out_sof),
   .out_data  (out_data)
);

// File: tb/sonet_frame_scrambler_tb.sv
module sonet_frame_scrambler_tb;
   localparam int NT        = 1;
   localparam int ROW_COLS  = 90 * NT;
   localparam int OH        = 3 * NT;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sof = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_valid, out_sof;
   logic [7:0] out_data;
   logic       rx_valid, rx_sof;
   logic [7:0] rx_data;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   sonet_frame_scrambler #(.N(NT), .PIPE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
      .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data));

   sonet_frame_scrambler #(.N(NT), .PIPE(1'b1)) u_rx (
      .clk(clk), .rst_n(rst_n), .in_valid(out_valid), .in_sof(out_sof), .in_data(out_data),
      .out_valid(rx_valid), .out_sof(rx_sof), .out_data(rx_data));

   // reference model state
   bit       m_locked = 0;
   int       m_row = 0, m_col = 0;
   bit [6:0] m_st = 7'h7F;
   bit       m_cut = 0;
   bit       prev_v = 0, prev_s = 0;
   bit [7:0] prev_d = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit [7:0] key_of(input bit [6:0] s);
      bit [7:0] k = 0;
      bit [6:0] t = s;
      for (int i = 0; i < 8; i++) begin
         k = {k[6:0], t[6]};
         t = {t[5:0], t[6] ^ t[5]};
      end
      return k;
   endfunction

   function automatic bit [6:0] adv8(input bit [6:0] s);
      bit [6:0] t = s;
      for (int i = 0; i < 8; i++) t = {t[5:0], t[6] ^ t[5]};
      return t;
   endfunction

   task automatic send(input bit v, input bit sof, input bit [7:0] d);
      bit [7:0] exp;
      string    tag;
      bit       lk;
      int       r, c;
      bit [6:0] st;
      @(negedge clk);
      in_valid = v; in_sof = sof; in_data = d;
      exp = d; tag = "R8";
      if (v) begin
         lk = sof | m_locked;
         r  = sof ? 0 : m_row;
         c  = sof ? 0 : m_col;
         if (sof) m_cut = (m_locked && !(m_row == 0 && m_col == 0));
         st = (lk && r == 0 && c == 0) ? 7'h7F : m_st;
         if (!lk) tag = "R2";
         else if (r == 0 && c < OH) tag = (c == 0 && !sof) ? "R10" : "R3";
         else if (r == 0 && c == OH) tag = m_cut ? "R7" : "R4";
         else if (c < OH) tag = "R6";
         else tag = "R5";
         if (lk && !(r == 0 && c < OH)) begin
            exp = d ^ key_of(st);
            st  = adv8(st);
         end
         m_st = st; m_locked = lk;
         c++;
         if (c == ROW_COLS) begin c = 0; r = (r == 8) ? 0 : r + 1; end
         m_row = r; m_col = c;
      end
      @(posedge clk); #2;
      check(out_valid == v, "R8 valid", out_valid, v);
      check(out_sof == (v & sof), "R8 sof", out_sof, v & sof);
      if (v) check(out_data == exp, tag, out_data, exp);
      check(rx_valid == prev_v, "R9 valid", rx_valid, prev_v);
      if (prev_v) begin
         check(rx_data == prev_d, "R9 data", rx_data, prev_d);
         check(rx_sof == prev_s, "R9 sof", rx_sof, prev_s);
      end
      prev_v = v; prev_s = v & sof; prev_d = d;
   endtask

   // stream cnt valid bytes with random gaps; optionally first one carries the strobe
   task automatic stream(input int cnt, input bit first_sof, input bit zeros);
      int sent = 0;
      while (sent < cnt) begin
         if (($urandom % 4) == 0) send(1'b0, 1'b0, 8'($urandom));
         else begin
            send(1'b1, first_sof && sent == 0, zeros ? 8'h00 : 8'($urandom));
            sent++;
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5C3A_91E7));
      repeat (3) @(posedge clk);
      #2;
      check(out_valid == 0 && out_sof == 0 && out_data == 0, "R1", out_data, 0);
      @(negedge clk); rst_n = 1'b1;
      stream(12, 1'b0, 1'b0);                 // R2 unlocked pass-through
      stream(OH + 4, 1'b1, 1'b1);             // R3/R4 with zero payload: output is the key
      stream(2 * 810 * NT + 60, 1'b0, 1'b0);  // R5 gaps, R6 later rows, R10 wrap
      stream(400, 1'b1, 1'b0);                // new frame
      stream(900, 1'b1, 1'b0);                // R7 early strobe, then wrap again
      send(1'b1, 1'b1, 8'hA5);                // back-to-back strobes
      send(1'b1, 1'b1, 8'h5A);
      stream(OH + 8, 1'b0, 1'b1);
      repeat (3) send(1'b0, 1'b0, 8'h00);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule